// File: doc/BRIEF.md
# Serial DAC Write Master

This block is the host-side driver for a dual-channel serial digital-to-analog converter that takes 16-bit command frames over a three-wire link: a frame strobe, a serial clock and a data line. A requester presents one command (target channel, operating mode, an 8-bit output code and a termination choice) together with a valid strobe. The master accepts it when its ready output is high and packs it into a 16-bit word. It then emits the frame MSB first and returns to idle once the inter-frame gap has elapsed.

The receiver latches the data line on each falling edge of the serial clock while the strobe is low. For this reason the master idles the serial clock high and changes the data line only on rising edges, so the data is always steady at the sampling edge. The serial clock comes from the system clock through a divider: each half period lasts `HALF_DIV` system cycles. The strobe goes low while the serial clock is high, half a period before the first falling edge. The strobe is held high for `GAP_CYC` system cycles both before and after each frame. Between commands the strobe and the data line rest low.

Top module: `dac_write_master`

## Requirements
- R1: After synchronous reset, the strobe is low, the data line is low, the serial clock is high and ready is high.
- R2: For modes 0, 1 and 2, the frame is, from first bit to last: a 0, the channel bit, mode bit 1, mode bit 0, the 8-bit code MSB first, then four 0 bits. As a word this is `{1'b0, chan, mode[1:0], code[7:0], 4'b0000}`.
- R3: For mode 3 (power-down), the first two bits carry the termination select (bit 1 first), the next two bits are 1 and 1, and the twelve data bits are all 0.
- R4: In modes 0, 1 and 2 the termination select has no effect on the frame.
- R5: While the strobe is low, the data line changes only in the same cycle as a rising serial-clock edge. It never changes at a falling edge.
- R6: The strobe falls while the serial clock is high, exactly `HALF_DIV` system cycles before the first falling edge.
- R7: During a frame, every high phase and every low phase of the serial clock lasts exactly `HALF_DIV` system cycles. Outside a frame the serial clock stays high.
- R8: Each high interval of the strobe, whether before or after a frame, lasts exactly `GAP_CYC` system cycles.
- R9: While the master is idle, the strobe and the data line are both low.
- R10: Ready drops in the cycle after a request is accepted. It stays low for `2*GAP_CYC + 32*HALF_DIV` cycles, through the post-frame gap. A request presented while ready is low is ignored and produces no frame.
- R11: Each frame holds exactly 16 falling serial-clock edges while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request strobe |
| req_chan | input | 1 | Target channel select |
| req_mode | input | 2 | Operating mode; 3 is power-down |
| req_code | input | 8 | Output code |
| req_term | input | 2 | Termination select, used only in mode 3 |
| req_ready | output | 1 | High when a new request can be accepted |
| dac_sync | output | 1 | Frame strobe, active low during a frame |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data, MSB first |

## Verification
The bench sweeps all 256 codes across the three write modes, with both channels and varying termination selects. It also sends every power-down termination value. A receiver model samples the data line on each falling edge and rebuilds each frame. A master that mispacked the word or leaked the termination select into a write frame would show a word mismatch. One that moved data on the falling edge, or dropped the strobe together with a falling edge, would break the stability and lead-time checks. A wrong divider or gap count would show up as an off-length clock phase or strobe interval. The bench keeps junk requests asserted throughout each busy period, so a master that accepted them would emit extra frames and fail the word comparison.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int FRAME_W = 16;
    localparam int DATA_W  = 12;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_POST  = 2'd3
    } dacw_state_e;

    localparam logic [1:0] MODE_PWRDN = 2'b11;

    typedef struct packed {
        logic       chan;
        logic [1:0] mode;
        logic [7:0] code;
        logic [1:0] term;
    } dacw_req_t;

    function automatic logic [FRAME_W-1:0] dacw_build(input dacw_req_t r);
        logic [FRAME_W-1:0] w;
        if (r.mode == MODE_PWRDN)
            w = {r.term, MODE_PWRDN, {DATA_W{1'b0}}};
        else
            w = {1'b0, r.chan, r.mode, r.code, {(DATA_W-8){1'b0}}};
        return w;
    endfunction

endpackage

// File: rtl/dacw_span.sv
module dacw_span #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dacw_engine.sv
module dacw_engine
    import dacw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  dacw_req_t req,
    input  logic      half_tick,
    input  logic      gap_tick,
    output logic      half_run,
    output logic      gap_run,
    output logic      req_ready,
    output logic      sync_o,
    output logic      sclk_o,
    output logic      din_o
);
    dacw_state_e        st;
    logic [FRAME_W-1:0] sreg;
    logic               half_lo;
    logic [BIT_W-1:0]   bitn;

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    assign half_run  = (st == ST_SHIFT);
    assign gap_run   = (st == ST_PRE) || (st == ST_POST);
    assign req_ready = (st == ST_IDLE) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sync_o  <= 1'b0;
            sclk_o  <= 1'b1;
            din_o   <= 1'b0;
            sreg    <= '0;
            half_lo <= 1'b0;
            bitn    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        sreg   <= dacw_build(req);
                        st     <= ST_PRE;
                        sync_o <= 1'b1;
                    end
                end
                ST_PRE: begin
                    if (gap_tick) begin
                        st      <= ST_SHIFT;
                        sync_o  <= 1'b0;
                        din_o   <= sreg[FRAME_W-1];
                        sreg    <= sreg << 1;
                        half_lo <= 1'b0;
                        bitn    <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (half_tick) begin
                        if (!half_lo) begin
                            sclk_o  <= 1'b0;
                            half_lo <= 1'b1;
                        end else begin
                            sclk_o  <= 1'b1;
                            half_lo <= 1'b0;
                            if (bitn == LAST_BIT) begin
                                st     <= ST_POST;
                                sync_o <= 1'b1;
                                din_o  <= 1'b0;
                            end else begin
                                bitn  <= bitn + 1'b1;
                                din_o <= sreg[FRAME_W-1];
                                sreg  <= sreg << 1;
                            end
                        end
                    end
                end
                ST_POST: begin
                    if (gap_tick) begin
                        st     <= ST_IDLE;
                        sync_o <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Data must hold across every sampling edge.
    assert_din_stable_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> $stable(din_o));

    // Strobe falls only while the serial clock rests high.
    assert_sync_fall_sclk_high_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_o) |-> (sclk_o && $stable(sclk_o)));

    // Idle lines rest low whenever a request can be taken.
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!sync_o && !din_o && sclk_o));

    // Acceptance makes the master busy on the next cycle.
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // Frame closes only after the final bit's low phase.
    assert_frame_end_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) && (st == ST_POST) |-> ($past(bitn) == LAST_BIT && $past(half_lo)));
endmodule

// File: rtl/dac_write_master.sv
module dac_write_master
    import dacw_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int GAP_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_chan,
    input  logic [1:0] req_mode,
    input  logic [7:0] req_code,
    input  logic [1:0] req_term,
    output logic       req_ready,
    output logic       dac_sync,
    output logic       dac_sclk,
    output logic       dac_din
);
    dacw_req_t req;
    logic      half_run, gap_run, half_tick, gap_tick;

    assign req = '{chan: req_chan, mode: req_mode, code: req_code, term: req_term};

    dacw_span #(.LEN(HALF_DIV)) u_half (
        .clk (clk), .rst (rst), .run (half_run), .done (half_tick)
    );

    dacw_span #(.LEN(GAP_CYC)) u_gap (
        .clk (clk), .rst (rst), .run (gap_run), .done (gap_tick)
    );

    dacw_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .half_tick (half_tick),
        .gap_tick  (gap_tick),
        .half_run  (half_run),
        .gap_run   (gap_run),
        .req_ready (req_ready),
        .sync_o    (dac_sync),
        .sclk_o    (dac_sclk),
        .din_o     (dac_din)
    );
endmodule

// File: tb/dac_write_master_bench.sv
module dac_write_master_bench;
    localparam int H    = 4;
    localparam int G    = 8;
    localparam int BUSY = 2*G + 32*H;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [7:0] req_code = 8'd0;
    logic [1:0] req_term = 2'd0;
    logic       req_ready, dac_sync, dac_sclk, dac_din;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_word [0:511];
    string       exp_tag  [0:511];
    int          n_exp = 0;
    int          n_got = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    dac_write_master #(.HALF_DIV(H), .GAP_CYC(G)) u_dac_write_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_mode(req_mode), .req_code(req_code), .req_term(req_term),
        .req_ready(req_ready), .dac_sync(dac_sync), .dac_sclk(dac_sclk),
        .dac_din(dac_din)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Receiver model and line-timing monitor, sampled mid-cycle.
    logic        p_sync = 1'b0, p_sclk = 1'b1, p_din = 1'b0;
    bit          in_frame = 0;
    int          run_len = 0, hi_len = 0, falls = 0;
    logic [15:0] cap = '0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (dac_sync) hi_len++;
            if (p_sync && !dac_sync) begin
                check(hi_len == G, "R8 gap length", hi_len, G);
                hi_len = 0;
                if (req_ready) begin
                    // post-frame gap ended into idle
                end else begin
                    in_frame = 1; run_len = 1; falls = 0; cap = '0;
                    check(dac_sclk == 1'b1, "R6 sclk high at strobe fall", dac_sclk, 1);
                end
            end else if (in_frame && dac_sync) begin
                check(run_len == H, "R7 last low phase", run_len, H);
                check(falls == 16, "R11 falling edges", falls, 16);
                if (n_got < n_exp)
                    check(cap == exp_word[n_got], exp_tag[n_got], cap, exp_word[n_got]);
                else
                    check(0, "R10 unexpected frame", cap, 0);
                n_got++;
                in_frame = 0;
            end else if (in_frame) begin
                if (dac_sclk == p_sclk) run_len++;
                else begin
                    if (falls == 0 && !dac_sclk)
                        check(run_len == H, "R6 lead before first fall", run_len, H);
                    else
                        check(run_len == H, "R7 phase length", run_len, H);
                    run_len = 1;
                end
                if (p_sclk && !dac_sclk) begin
                    check(dac_din == p_din, "R5 data at falling edge", dac_din, p_din);
                    cap = {cap[14:0], dac_din};
                    falls++;
                end
                if (dac_din != p_din && !(!p_sclk && dac_sclk))
                    check(0, "R5 data moved off rising edge", dac_din, p_din);
            end else if (!dac_sync) begin
                if (dac_din !== 1'b0 || dac_sclk !== 1'b1)
                    check(0, "R9 idle lines", {dac_sclk, dac_din}, 2'b10);
            end
        end
        p_sync = dac_sync; p_sclk = dac_sclk; p_din = dac_din;
    end

    task automatic send(input logic ch, input logic [1:0] md, input logic [7:0] cd,
                        input logic [1:0] tm, input string tag);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_mode = md; req_code = cd; req_term = tm;
        if (md == 2'b11) exp_word[n_exp] = {tm, 2'b11, 12'h000};
        else             exp_word[n_exp] = {1'b0, ch, md, cd, 4'h0};
        exp_tag[n_exp] = tag;
        n_exp++;
        @(negedge clk);
        // junk held high while busy must be ignored
        req_chan = ~ch; req_mode = 2'b11; req_code = ~cd; req_term = ~tm;
        check(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
        n = 0;
        while (!req_ready) begin n++; @(negedge clk); end
        req_valid = 1'b0;
        check(n == BUSY, "R10 busy length", n, BUSY);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(dac_sync == 1'b0, "R1 strobe", dac_sync, 0);
        check(dac_din == 1'b0, "R1 data", dac_din, 0);
        check(dac_sclk == 1'b1, "R1 sclk", dac_sclk, 1);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        for (int c = 0; c < 256; c++)
            send(c[0], 2'(c % 3), 8'(c), 2'b00, "R2 write frame");
        for (int t = 0; t < 4; t++)
            send(t[0], 2'b11, 8'(8'hA5 + t), 2'(t), "R3 power-down frame");
        for (int k = 0; k < 12; k++)
            send(k[1], 2'(k % 3), 8'(8'h3C ^ (k * 17)), 2'(k % 4), "R4 term ignored");
        repeat (3*G) @(negedge clk);
        check(n_got == n_exp, "R10 frame count", n_got, n_exp);
        check(dac_sync == 1'b0 && dac_din == 1'b0, "R9 final idle", {dac_sync, dac_din}, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule